// File: doc/BRIEF.md
# Length-Prefixed Frame Capture Engine

The block sits behind the byte stream of an SPI target and gathers one frame at a time into a local byte buffer of fixed size. Each frame opens with a two-byte big-endian length field, which counts the payload bytes that follow. The engine works out the total frame size from that field. It then writes the header and the payload into the buffer, starting at an offset that moves on by one position, modulo three, for every new frame. This rotation lets software that loops the frame back test all alignments of the buffer.

When the last byte has been written, the engine raises a done flag. It reports the captured length and the start offset, and it waits for the chip-select-deasserted pulse before it accepts a new header. A frame whose size would run past the end of the buffer is not captured: the engine goes straight to the finished state with a length of zero. A read port with one cycle of latency gives a retransmit path or a testbench access to the captured bytes.

Top module: `lpf_capture`

## Requirements
- R1: After reset, frame_done is 0, frame_len is 0 and frame_base is 0.
- R2: The first two accepted bytes of a frame form the length field, first byte most significant. The total frame size is first*256 + second + 2.
- R3: Each evaluated header sets frame_base to (previous frame_base + 1) mod 3, so the first frame after reset starts at offset 1. An aborted partial header leaves frame_base unchanged.
- R4: The bytes of a captured frame, header included, are written to consecutive buffer addresses from frame_base upward. rd_data shows the byte at rd_addr one clock after rd_addr is sampled.
- R5: On the clock edge that accepts the final byte of a frame that fits, frame_done goes to 1. From that edge, frame_len shows the total frame size.
- R6: If frame_base + total size exceeds BUF_BYTES, the engine enters the finished state on the edge that accepts the second header byte, with frame_len 0. It stores no byte past the first header byte, and the buffer keeps its earlier contents.
- R7: While finished, frame_done stays 1 and accepted bytes change neither the buffer nor the outputs. A cs_end pulse returns the engine to not started, so frame_done is 0 after that edge.
- R8: A cs_end pulse when only one header byte has arrived discards that byte's header role. The next byte is treated as a fresh first header byte.
- R9: A cs_end pulse while payload is still due has no effect. Capture goes on with the next accepted bytes.
- R10: When byte_vld and cs_end are high in the same cycle, the byte is handled first and cs_end then acts on the resulting state. A frame that completes on a byte that coincides with cs_end therefore leaves frame_done at 0, with frame_len and frame_base updated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_vld | input | 1 | A received byte is present on byte_data |
| byte_data | input | 8 | Received byte |
| cs_end | input | 1 | One-cycle pulse: chip select has deasserted |
| frame_done | output | 1 | Engine is in the finished state |
| frame_len | output | LEN_W | Captured length (end index minus start offset) |
| frame_base | output | 2 | Start offset of the latest frame |
| rd_addr | input | ADDR_W | Buffer read address |
| rd_data | output | 8 | Buffer byte at rd_addr, one cycle later |

## Verification
Two events can land in the same cycle: the last byte of a frame can coincide with the cs_end pulse, and a first header byte can coincide with an abort. The random stimulus ends some frames with a separate pulse and others with a pulse on the final byte. It also drops single header bytes with a pulse and pulses during payload. The bench model applies the byte and then the pulse, so it predicts a cleared done flag, an updated length, and the stored bytes read back through the port.

// File: rtl/lpf_pkg.sv
package lpf_pkg;
    typedef enum logic [1:0] {
        LPF_ARMED = 2'd0,
        LPF_FILL  = 2'd1,
        LPF_HOLD  = 2'd2
    } lpf_state_e;

    // header is 16 bits, plus the two header bytes themselves
    localparam int unsigned LPF_SIZE_W = 17;
endpackage

// File: rtl/lpf_hdr_eval.sv
module lpf_hdr_eval
    import lpf_pkg::*;
#(
    parameter int unsigned BUF_BYTES = 1100
) (
    input  logic [1:0]            base_q,
    input  logic [7:0]            hi_byte,
    input  logic [7:0]            lo_byte,
    output logic [1:0]            base_nxt,
    output logic [LPF_SIZE_W-1:0] total,
    output logic                  fits
);
    localparam int unsigned SPAN_W = LPF_SIZE_W + 1;

    logic [SPAN_W-1:0] span;

    always_comb begin
        base_nxt = (base_q == 2'd2) ? 2'd0 : base_q + 2'd1;
        total    = {1'b0, hi_byte, lo_byte} + LPF_SIZE_W'(2);
        span     = SPAN_W'(base_nxt) + SPAN_W'(total);
        fits     = (span <= SPAN_W'(BUF_BYTES));
    end
endmodule

// File: rtl/lpf_buf_ram.sv
module lpf_buf_ram #(
    parameter int unsigned DEPTH  = 1100,
    parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/lpf_capture.sv
module lpf_capture
    import lpf_pkg::*;
#(
    parameter int unsigned BUF_BYTES = 1100,
    parameter int unsigned ADDR_W    = $clog2(BUF_BYTES),
    parameter int unsigned LEN_W     = $clog2(BUF_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [7:0]        byte_data,
    input  logic              cs_end,
    output logic              frame_done,
    output logic [LEN_W-1:0]  frame_len,
    output logic [1:0]        frame_base,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    typedef struct packed {
        lpf_state_e            st;
        logic [1:0]            base;
        logic [LEN_W-1:0]      idx;
        logic [LPF_SIZE_W-1:0] rem;
        logic                  hdr_got;
        logic [7:0]            hi;
    } cap_t;

    cap_t cap_d, cap_q;

    logic [1:0]            base_cand;
    logic [LPF_SIZE_W-1:0] total;
    logic                  fits;

    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;

    lpf_hdr_eval #(.BUF_BYTES(BUF_BYTES)) u_hdr (
        .base_q   (cap_q.base),
        .hi_byte  (cap_q.hi),
        .lo_byte  (byte_data),
        .base_nxt (base_cand),
        .total    (total),
        .fits     (fits)
    );

    lpf_buf_ram #(.DEPTH(BUF_BYTES), .ADDR_W(ADDR_W)) u_ram (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (byte_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    always_comb begin
        cap_d     = cap_q;
        mem_we    = 1'b0;
        mem_waddr = '0;

        // byte first, then the chip-select release acts on the outcome
        if (byte_vld) begin
            unique case (cap_q.st)
                LPF_ARMED: begin
                    if (!cap_q.hdr_got) begin
                        cap_d.hdr_got = 1'b1;
                        cap_d.hi      = byte_data;
                        mem_we        = 1'b1;
                        mem_waddr     = ADDR_W'(base_cand);
                    end else begin
                        cap_d.hdr_got = 1'b0;
                        cap_d.base    = base_cand;
                        if (fits) begin
                            mem_we    = 1'b1;
                            mem_waddr = ADDR_W'(base_cand) + ADDR_W'(1);
                            cap_d.idx = LEN_W'(base_cand) + LEN_W'(2);
                            cap_d.rem = total - LPF_SIZE_W'(2);
                            cap_d.st  = (total == LPF_SIZE_W'(2)) ? LPF_HOLD : LPF_FILL;
                        end else begin
                            cap_d.idx = LEN_W'(base_cand);
                            cap_d.st  = LPF_HOLD;
                        end
                    end
                end
                LPF_FILL: begin
                    mem_we    = 1'b1;
                    mem_waddr = ADDR_W'(cap_q.idx);
                    cap_d.idx = cap_q.idx + LEN_W'(1);
                    cap_d.rem = cap_q.rem - LPF_SIZE_W'(1);
                    if (cap_q.rem == LPF_SIZE_W'(1)) begin
                        cap_d.st = LPF_HOLD;
                    end
                end
                LPF_HOLD: begin
                end
                default: cap_d.st = LPF_ARMED;
            endcase
        end

        if (cs_end) begin
            if (cap_d.st == LPF_ARMED) begin
                cap_d.hdr_got = 1'b0;
            end else if (cap_d.st == LPF_HOLD) begin
                cap_d.st = LPF_ARMED;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '{st: LPF_ARMED, base: 2'd0, idx: '0, rem: '0, hdr_got: 1'b0, hi: 8'd0};
        end else begin
            cap_q <= cap_d;
        end
    end

    assign frame_done = (cap_q.st == LPF_HOLD);
    assign frame_len  = cap_q.idx - LEN_W'(cap_q.base);
    assign frame_base = cap_q.base;
endmodule

// File: rtl/lpf_capture_chk.sv
module lpf_capture_chk #(
    parameter int unsigned BUF_BYTES = 1100,
    parameter int unsigned LEN_W     = $clog2(BUF_BYTES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_end,
    input logic             frame_done,
    input logic [LEN_W-1:0] frame_len,
    input logic [1:0]       frame_base,
    input logic             mem_we
);
    // R3: offset never leaves 0..2
    p_base_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_base <= 2'd2);

    // R3: offset only ever advances by one, modulo three
    p_base_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_base != $past(frame_base)) |->
        (frame_base == (($past(frame_base) == 2'd2) ? 2'd0 : $past(frame_base) + 2'd1)));

    // R5: captured length stays inside the buffer
    p_len_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(frame_len) + 32'(frame_base)) <= BUF_BYTES);

    // R7: finished state persists until the release pulse
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !cs_end) |=> frame_done);

    // R7: release pulse re-arms
    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && cs_end) |=> !frame_done);

    // R7: no buffer writes while finished
    p_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !mem_we);

    // R7: reported length and offset frozen while finished
    p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !cs_end) |=> ($stable(frame_len) && $stable(frame_base)));
endmodule

bind lpf_capture lpf_capture_chk #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_end     (cs_end),
    .frame_done (frame_done),
    .frame_len  (frame_len),
    .frame_base (frame_base),
    .mem_we     (mem_we)
);

// File: tb/lpf_capture_tb.sv
`timescale 1ns/1ps
module lpf_capture_tb;
    localparam int BUF  = 1100;
    localparam int AW   = $clog2(BUF);
    localparam int LW   = $clog2(BUF + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          byte_vld = 1'b0;
    logic [7:0]    byte_data = 8'd0;
    logic          cs_end = 1'b0;
    logic          frame_done;
    logic [LW-1:0] frame_len;
    logic [1:0]    frame_base;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;

    int checks = 0;
    int fails  = 0;

    // bench model state
    byte unsigned exp_mem [BUF];
    bit           exp_ok  [BUF];
    int m_st = 0;   // 0 not started, 1 receiving, 2 finished
    int m_base = 0, m_idx = 0, m_rem = 0, m_hi = 0;
    bit m_hdr = 0;

    lpf_capture #(.BUF_BYTES(BUF)) u_dut (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
        .cs_end(cs_end), .frame_done(frame_done), .frame_len(frame_len),
        .frame_base(frame_base), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: run hung, actual=running expected=finished");
        summary();
        $finish;
    end

    task automatic cmp(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int next_base(int b);
        return (b + 1) % 3;
    endfunction

    // R2 R6 R10: byte handled first, release pulse afterwards
    task automatic model(bit v, int d, bit cs);
        int cb, size;
        if (v) begin
            if (m_st == 0) begin
                cb = next_base(m_base);
                if (!m_hdr) begin
                    exp_mem[cb] = byte'(d); exp_ok[cb] = 1; m_hi = d; m_hdr = 1;
                end else begin
                    size = m_hi * 256 + d + 2;
                    m_base = cb; m_hdr = 0;
                    if (cb + size > BUF) begin
                        m_idx = cb; m_st = 2;
                    end else begin
                        exp_mem[cb+1] = byte'(d); exp_ok[cb+1] = 1;
                        m_idx = cb + 2; m_rem = size - 2;
                        m_st = (m_rem == 0) ? 2 : 1;
                    end
                end
            end else if (m_st == 1) begin
                exp_mem[m_idx] = byte'(d); exp_ok[m_idx] = 1;
                m_idx++; m_rem--;
                if (m_rem == 0) m_st = 2;
            end
        end
        if (cs) begin
            if (m_st == 0) m_hdr = 0;
            else if (m_st == 2) m_st = 0;
        end
    endtask

    task automatic drive(bit v, int d, bit cs);
        byte_vld  = v;
        byte_data = 8'(d);
        cs_end    = cs;
        @(posedge clk);
        model(v, d, cs);
        @(negedge clk);
        byte_vld = 1'b0;
        cs_end   = 1'b0;
        cmp("R5/R7 frame_done", int'(frame_done), (m_st == 2) ? 1 : 0);
        cmp("R5/R6 frame_len", int'(frame_len), m_idx - m_base);
        cmp("R3 frame_base", int'(frame_base), m_base);
    endtask

    // R4: read back through the port, one cycle latency
    task automatic check_mem(int lo, int hi);
        for (int a = lo; a < hi; a++) begin
            if (exp_ok[a]) begin
                rd_addr = AW'(a);
                @(posedge clk);
                @(negedge clk);
                cmp("R4 rd_data", int'(rd_data), int'(exp_mem[a]));
            end
        end
    endtask

    // payload of plen bytes; mode 0 separate release, 1 release on last byte (R10)
    task automatic send_frame(int plen, int mode, bit mid_cs);
        int total;
        total = plen + 2;
        for (int i = 0; i < total; i++) begin
            int d;
            bit last;
            if (i == 0) d = (plen >> 8) & 255;
            else if (i == 1) d = plen & 255;
            else d = int'($urandom % 256);
            last = (i == total - 1);
            if (mid_cs && i == 3 && !last) drive(1'b0, 0, 1'b1); // R9
            if (($urandom % 4) == 0) drive(1'b0, 0, 1'b0);
            drive(1'b1, d, last && mode == 1);
        end
    endtask

    initial begin
        void'($urandom(32'h1d2c3b4a));
        for (int i = 0; i < BUF; i++) exp_ok[i] = 0;
        repeat (3) @(negedge clk);
        // R1: reset values
        cmp("R1 frame_done", int'(frame_done), 0);
        cmp("R1 frame_len", int'(frame_len), 0);
        cmp("R1 frame_base", int'(frame_base), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed: empty payload, base 1 (R2, R3, R5)
        send_frame(0, 0, 0);
        check_mem(0, 4);
        drive(1'b1, 8'h77, 1'b0);  // R7: ignored byte
        drive(1'b0, 0, 1'b1);

        // directed: partial header aborted (R8)
        drive(1'b1, 8'h00, 1'b0);
        drive(1'b0, 0, 1'b1);
        send_frame(5, 0, 0);
        check_mem(0, m_idx);
        drive(1'b0, 0, 1'b1);

        // directed: header byte and abort in the same cycle (R8, R10)
        drive(1'b1, 8'h00, 1'b1);
        send_frame(3, 1, 0);
        check_mem(0, m_idx);

        // directed: frame that exactly fills the buffer
        send_frame(BUF - next_base(m_base) - 2, 0, 0);
        check_mem(0, BUF);
        drive(1'b0, 0, 1'b1);

        // directed: one byte too large, rejected (R6)
        send_frame(BUF - next_base(m_base) - 1, 0, 0);
        cmp("R6 len zero", int'(frame_len), 0);
        check_mem(0, 16);
        drive(1'b0, 0, 1'b1);

        // directed: release during payload ignored (R9)
        send_frame(6, 0, 1);
        check_mem(0, m_idx);
        drive(1'b0, 0, 1'b1);

        // random frames
        for (int f = 0; f < 80; f++) begin
            int plen;
            int mode;
            plen = int'($urandom % 24);
            mode = int'($urandom % 2);
            if (($urandom % 6) == 0) begin
                drive(1'b1, int'($urandom % 256), 1'b0);
                drive(1'b0, 0, 1'b1);  // R8 abort
            end
            send_frame(plen, mode, ($urandom % 5) == 0);
            check_mem(0, m_idx);
            if (mode == 0) begin
                repeat (int'($urandom % 3)) drive(1'b1, int'($urandom % 256), 1'b0); // R7
                drive(1'b0, 0, 1'b1);
            end
        end

        summary();
        $finish;
    end
endmodule